// File: doc/BRIEF.md
# Serial Slave Configuration Sequencer

This block loads a programmable device through its serial slave configuration pins. It drives three outputs: a program strobe, a configuration clock and a serial data line. It watches two inputs from the device: an init status line and a done line. A one-cycle `start` pulse begins a load. The block pulses the program strobe active and waits for init to fall. It then releases the strobe and waits for init to rise. After that it takes configuration words over a valid/ready interface and shifts each word out on the data line, most significant bit first. After the word flagged as last, it waits for done and reports the outcome.

Each of the three waits has its own timeout and its own result code. A timeout is `POLL_TICKS * MAX_POLLS` clock cycles. The init and done inputs pass through a two-flop synchronizer before the state machine uses them. The states are IDLE, WAIT_INIT_LO, WAIT_INIT_HI, WORD_WAIT, BIT_CLK_LO, BIT_SETUP, BIT_CLK_HI, BIT_RESTORE and WAIT_DONE. The transitions are:

- IDLE to WAIT_INIT_LO on `start`.
- WAIT_INIT_LO to WAIT_INIT_HI when init reads low, or to IDLE with code 1 on timeout.
- WAIT_INIT_HI to WORD_WAIT when init reads high, or to IDLE with code 2 on timeout.
- WORD_WAIT to BIT_CLK_LO on a word handshake.
- BIT_CLK_LO to BIT_SETUP, then BIT_CLK_HI, then BIT_RESTORE.
- BIT_RESTORE back to BIT_CLK_LO for the next bit of the word, to WORD_WAIT after the last bit of a normal word, or to WAIT_DONE after the last bit of the last word.
- WAIT_DONE to IDLE with code 0 when done reads high, or to IDLE with code 3 on timeout.

Top module: `cfg_loader`

## Requirements
- R1: After reset and whenever idle, `prog_o` is at its inactive level, `cclk_o` and `cdata_o` are 1, and `busy` and `word_ready` are 0.
- R2: A `start` pulse seen while idle makes `prog_o` active and `busy` 1 after the next clock edge. A `start` pulse while busy has no effect: it neither restarts the sequence nor resets its timer.
- R3: `prog_o` stays active until init has been low through the two synchronizer flops. It goes inactive on the third clock edge after init falls.
- R4: `word_ready` stays 0 until init has returned high after `prog_o` was released. No bit is shifted before that.
- R5: Each bit takes four cycles. In cycle 1 the clock is 0 and data is 1. In cycle 2 the clock is 0 and data is the bit. In cycle 3 the clock is 1 and data holds the bit. In cycle 4 the clock is 1 and data returns to 1. Data never changes on the cycle the clock rises.
- R6: Words are sent in handshake order, each one most significant bit first. The word accepted with `word_last` = 1 is the final word before the done wait.
- R7: When done reads high after the final word, `result_code` = 0. `result_valid` pulses for exactly one cycle in the same cycle that `busy` falls.
- R8: If init never falls while the strobe is active, `result_code` = 1. `result_valid` rises at the `POLL_TICKS*MAX_POLLS+1`th clock edge after the edge that took `start`.
- R9: If init never returns high after the strobe is released, `result_code` = 2.
- R10: If done never rises after the final word, `result_code` = 3.
- R11: With `PROG_ACTIVE_HIGH` = 1 the active level of `prog_o` is 1; with 0 it is 0.
- R12: After any result the block returns to idle with all pins at their inactive level. `result_code` holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a configuration sequence |
| word_valid | input | 1 | Configuration word offered |
| word_data | input | WORD_W | Configuration word, sent MSB first |
| word_last | input | 1 | Offered word is the final one |
| word_ready | output | 1 | Sequencer accepts a word this cycle |
| dev_init | input | 1 | Device init status line (asynchronous) |
| dev_done | input | 1 | Device done line (asynchronous) |
| prog_o | output | 1 | Program strobe, polarity by parameter |
| cclk_o | output | 1 | Configuration clock |
| cdata_o | output | 1 | Configuration data |
| busy | output | 1 | Sequence in progress |
| result_valid | output | 1 | One-cycle pulse when a result is latched |
| result_code | output | 2 | 0 success, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The pins are decoded from the state register, so `prog_o` and `busy` change one clock edge after `start`. A change on init or done reaches the state machine through two synchronizer flops, so its effect appears on the third edge after the input moves. An init-low timeout ends with `result_valid` one edge after `POLL_TICKS*MAX_POLLS` edges of waiting. The bench drives inputs and samples outputs on the falling clock edge and counts those edges from the stimulus, so the init-release and timeout checks compare the exact edge count. The serial checks follow the configuration clock cycle by cycle: they check data stability on each rise, and they compare the captured stream with the table of words.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_INIT_LO,
        ST_WAIT_INIT_HI,
        ST_WORD_WAIT,
        ST_BIT_CLK_LO,
        ST_BIT_SETUP,
        ST_BIT_CLK_HI,
        ST_BIT_RESTORE,
        ST_WAIT_DONE
    } cfg_state_e;

    typedef enum logic [1:0] {
        RES_OK          = 2'd0,
        RES_INIT_LO_TMO = 2'd1,
        RES_INIT_HI_TMO = 2'd2,
        RES_DONE_TMO    = 2'd3
    } cfg_result_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= (g == 0) ? async_i : stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
    parameter int POLL_TICKS = 8,
    parameter int MAX_POLLS  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expired
);
    localparam int TICK_W = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    logic [TICK_W-1:0] tick_q;
    logic [POLL_W-1:0] polls_q;

    assign expired = (polls_q == POLL_W'(MAX_POLLS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else if (clr || !run) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else if (!expired) begin
            if (tick_q == TICK_W'(POLL_TICKS - 1)) begin
                tick_q  <= '0;
                polls_q <= polls_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int WORD_W           = 8,
    parameter int POLL_TICKS       = 8,
    parameter int MAX_POLLS        = 5,
    parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_last,
    output logic              word_ready,
    input  logic              dev_init,
    input  logic              dev_done,
    output logic              prog_o,
    output logic              cclk_o,
    output logic              cdata_o,
    output logic              busy,
    output logic              result_valid,
    output logic [1:0]        result_code
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    cfg_state_e        state_q, state_d;
    logic [WORD_W-1:0] shift_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              last_q;
    logic              res_valid_q;
    logic [1:0]        res_code_q;
    logic              finish_d;
    cfg_result_e       code_d;
    logic              init_s, done_s;
    logic              tmr_run, tmr_clr, tmr_expired;
    logic              load_word, next_bit;
    logic              prog_act;

    cfg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dev_done, dev_init}),
        .sync_o  ({done_s, init_s})
    );

    cfg_poll_timer #(.POLL_TICKS(POLL_TICKS), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clr     (tmr_clr),
        .expired (tmr_expired)
    );

    assign tmr_run = (state_q == ST_WAIT_INIT_LO) || (state_q == ST_WAIT_INIT_HI) ||
                     (state_q == ST_WAIT_DONE);
    assign tmr_clr = (state_d != state_q);

    // next-state logic
    always_comb begin
        state_d   = state_q;
        finish_d  = 1'b0;
        code_d    = RES_OK;
        load_word = 1'b0;
        next_bit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_INIT_LO;
            end
            ST_WAIT_INIT_LO: begin
                if (!init_s) begin
                    state_d = ST_WAIT_INIT_HI;
                end else if (tmr_expired) begin
                    state_d  = ST_IDLE;
                    finish_d = 1'b1;
                    code_d   = RES_INIT_LO_TMO;
                end
            end
            ST_WAIT_INIT_HI: begin
                if (init_s) begin
                    state_d = ST_WORD_WAIT;
                end else if (tmr_expired) begin
                    state_d  = ST_IDLE;
                    finish_d = 1'b1;
                    code_d   = RES_INIT_HI_TMO;
                end
            end
            ST_WORD_WAIT: begin
                if (word_valid) begin
                    state_d   = ST_BIT_CLK_LO;
                    load_word = 1'b1;
                end
            end
            ST_BIT_CLK_LO:  state_d = ST_BIT_SETUP;
            ST_BIT_SETUP:   state_d = ST_BIT_CLK_HI;
            ST_BIT_CLK_HI:  state_d = ST_BIT_RESTORE;
            ST_BIT_RESTORE: begin
                if (bit_idx_q == IDX_W'(WORD_W - 1)) begin
                    state_d = last_q ? ST_WAIT_DONE : ST_WORD_WAIT;
                end else begin
                    state_d  = ST_BIT_CLK_LO;
                    next_bit = 1'b1;
                end
            end
            ST_WAIT_DONE: begin
                if (done_s) begin
                    state_d  = ST_IDLE;
                    finish_d = 1'b1;
                    code_d   = RES_OK;
                end else if (tmr_expired) begin
                    state_d  = ST_IDLE;
                    finish_d = 1'b1;
                    code_d   = RES_DONE_TMO;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // word shifter and result latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            bit_idx_q   <= '0;
            last_q      <= 1'b0;
            res_valid_q <= 1'b0;
            res_code_q  <= 2'd0;
        end else begin
            if (load_word) begin
                shift_q   <= word_data;
                last_q    <= word_last;
                bit_idx_q <= '0;
            end else if (next_bit) begin
                shift_q   <= {shift_q[WORD_W-2:0], 1'b0};
                bit_idx_q <= bit_idx_q + 1'b1;
            end
            res_valid_q <= finish_d;
            if (finish_d) res_code_q <= code_d;
        end
    end

    // pin outputs decoded from state
    always_comb begin
        prog_act   = (state_q == ST_WAIT_INIT_LO);
        prog_o     = PROG_ACTIVE_HIGH ? prog_act : !prog_act;
        cclk_o     = !((state_q == ST_BIT_CLK_LO) || (state_q == ST_BIT_SETUP));
        cdata_o    = ((state_q == ST_BIT_SETUP) || (state_q == ST_BIT_CLK_HI)) ?
                     shift_q[WORD_W-1] : 1'b1;
        word_ready = (state_q == ST_WORD_WAIT);
        busy       = (state_q != ST_IDLE);
    end

    assign result_valid = res_valid_q;
    assign result_code  = res_code_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic word_ready,
    input logic prog_o,
    input logic cclk_o,
    input logic cdata_o,
    input logic busy,
    input logic result_valid
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cclk_o && cdata_o && (prog_o == !PROG_ACTIVE_HIGH) && !word_ready));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && (prog_o == PROG_ACTIVE_HIGH)));

    // R4
    ready_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (busy && (prog_o == !PROG_ACTIVE_HIGH)));

    // R5
    clk_rise_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(cdata_o));

    // R5
    data_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o) && !$stable(cdata_o)) |-> cdata_o);

    // R7
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> result_valid);
endmodule

bind cfg_loader cfg_loader_chk #(.PROG_ACTIVE_HIGH(PROG_ACTIVE_HIGH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .word_ready   (word_ready),
    .prog_o       (prog_o),
    .cclk_o       (cclk_o),
    .cdata_o      (cdata_o),
    .busy         (busy),
    .result_valid (result_valid)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    localparam int P = 8;
    localparam int M = 5;
    localparam int NV = 5;
    // stimulus word, expected serial order (first bit leftmost)
    localparam logic [15:0] VEC [NV] = '{
        {8'hA5, 8'b10100101},
        {8'h00, 8'b00000000},
        {8'hFF, 8'b11111111},
        {8'h3C, 8'b00111100},
        {8'h81, 8'b10000001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, word_valid = 1'b0, word_last = 1'b0;
    logic [7:0] word_data = 8'h00;
    logic dev_init = 1'b1, dev_done = 1'b0;
    logic word_ready, prog_o, cclk_o, cdata_o, busy, result_valid;
    logic [1:0] result_code;

    logic start_hi = 1'b0;
    logic ready_hi, prog_hi, cclk_hi, cdata_hi, busy_hi, rv_hi;
    logic [1:0] rc_hi;

    int tests = 0, fails = 0;
    int nbits = 0;
    logic cap [0:63];
    logic prev_clk = 1'b1, prev_data = 1'b1;

    always #5 clk = ~clk;

    cfg_loader #(.WORD_W(8), .POLL_TICKS(P), .MAX_POLLS(M), .PROG_ACTIVE_HIGH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
        .word_data(word_data), .word_last(word_last), .word_ready(word_ready),
        .dev_init(dev_init), .dev_done(dev_done), .prog_o(prog_o), .cclk_o(cclk_o),
        .cdata_o(cdata_o), .busy(busy), .result_valid(result_valid),
        .result_code(result_code));

    cfg_loader #(.WORD_W(8), .POLL_TICKS(P), .MAX_POLLS(M), .PROG_ACTIVE_HIGH(1'b1)) uut_hi (
        .clk(clk), .rst_n(rst_n), .start(start_hi), .word_valid(1'b0),
        .word_data(8'h00), .word_last(1'b0), .word_ready(ready_hi),
        .dev_init(1'b1), .dev_done(1'b0), .prog_o(prog_hi), .cclk_o(cclk_hi),
        .cdata_o(cdata_hi), .busy(busy_hi), .result_valid(rv_hi),
        .result_code(rc_hi));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // serial monitor: R5 per-cycle steps, capture bits on clock rise
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_clk && !cclk_o)
                check(cdata_o == 1'b1, "R5 data high at clock fall", cdata_o, 1);
            if (!prev_clk && cclk_o) begin
                check(cdata_o == prev_data, "R5 data stable at clock rise", cdata_o, prev_data);
                if (nbits < 64) cap[nbits] = cdata_o;
                nbits++;
            end
            prev_clk  = cclk_o;
            prev_data = cdata_o;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_result(inout int k, output logic [1:0] code);
        while (!result_valid && k < 3000) begin
            @(negedge clk);
            k++;
        end
        code = result_code;
    endtask

    task automatic send_word(input logic [7:0] d, input logic last);
        word_valid = 1'b1; word_data = d; word_last = last;
        for (int n = 0; n < 3000; n++) begin
            if (word_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        word_valid = 1'b0; word_last = 1'b0;
    endtask

    // bring sequencer through both init phases
    task automatic do_handshake();
        pulse_start();
        repeat (2) @(negedge clk);
        dev_init = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(prog_o == 1'b0, "R3 prog active two edges after init fall", prog_o, 0);
        @(negedge clk);
        check(prog_o == 1'b1, "R3 prog released on third edge", prog_o, 1);
        repeat (4) @(negedge clk);
        check(word_ready == 1'b0, "R4 no ready while init low", word_ready, 0);
        dev_init = 1'b1;
        repeat (3) @(negedge clk);
        check(word_ready == 1'b1, "R4 ready after init high", word_ready, 1);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int k;
        logic [1:0] code;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(prog_o == 1'b1 && cclk_o && cdata_o, "R1 idle pins", {prog_o, cclk_o, cdata_o}, 7);
        check(!busy && !word_ready, "R1 not busy", {busy, word_ready}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!busy && prog_o, "R1 idle after reset", {busy, prog_o}, 1);
        // R11 polarity
        check(prog_hi == 1'b0, "R11 active-high idle level", prog_hi, 0);

        // vector table: full successful load
        nbits = 0;
        do_handshake();
        for (int i = 0; i < NV; i++) send_word(VEC[i][15:8], i == NV - 1);
        k = 0;
        while (busy && cclk_o == 1'b1 && nbits < NV*8 && k < 3000) begin @(negedge clk); k++; end
        for (int n = 0; n < 3000 && nbits < NV*8; n++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(busy && !result_valid, "R7 waiting for done", busy, 1);
        dev_done = 1'b1;
        k = 0;
        wait_result(k, code);
        check(code == 2'd0 && result_valid, "R7 success code", code, 0);
        check(!busy, "R7 busy falls with result", busy, 0);
        @(negedge clk);
        check(!result_valid, "R7 single pulse", result_valid, 0);
        check(nbits == NV*8, "R6 bit count", nbits, NV*8);
        for (int i = 0; i < NV; i++) begin
            logic [7:0] got;
            for (int b = 0; b < 8; b++) got[7-b] = cap[i*8+b];
            check(got == VEC[i][7:0], "R6 word order MSB first", got, VEC[i][7:0]);
        end
        dev_done = 1'b0;
        repeat (4) @(negedge clk);
        check(result_code == 2'd0 && prog_o && cclk_o && cdata_o, "R12 held code and idle pins",
              result_code, 0);

        // R8 init never falls, with R2 ignored second start
        pulse_start();
        check(busy && prog_o == 1'b0, "R2 start activates prog", {busy, prog_o}, 2);
        k = 1;
        repeat (8) begin @(negedge clk); k++; end
        pulse_start();
        k++;
        wait_result(k, code);
        check(code == 2'd1, "R8 init-low timeout code", code, 1);
        check(k == P*M + 2, "R8 timeout edge count (R2 restart ignored)", k, P*M + 2);
        @(negedge clk);
        check(prog_o && !busy && result_code == 2'd1, "R12 idle after error", result_code, 1);

        // R9 init never returns high
        pulse_start();
        repeat (2) @(negedge clk);
        dev_init = 1'b0;
        k = 0;
        wait_result(k, code);
        check(code == 2'd2, "R9 init-high timeout code", code, 2);
        check(word_ready == 1'b0 && nbits == NV*8, "R4 no shifting without init high", nbits, NV*8);
        dev_init = 1'b1;
        repeat (4) @(negedge clk);

        // R10 done never rises
        nbits = 0;
        do_handshake();
        send_word(8'h5A, 1'b1);
        k = 0;
        wait_result(k, code);
        check(code == 2'd3, "R10 done timeout code", code, 3);
        check(nbits == 8, "R6 single word sent", nbits, 8);
        repeat (3) @(negedge clk);
        check(result_code == 2'd3 && cclk_o && cdata_o && prog_o, "R12 code held", result_code, 3);

        // R11 active-high instance
        start_hi = 1'b1;
        @(negedge clk);
        start_hi = 1'b0;
        check(prog_hi == 1'b1 && busy_hi, "R11 active-high strobe", prog_hi, 1);
        for (int n = 0; n < 200 && !rv_hi; n++) @(negedge clk);
        check(rc_hi == 2'd1, "R11 instance timeout code", rc_hi, 1);
        @(negedge clk);
        check(prog_hi == 1'b0, "R11 returns to inactive low", prog_hi, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule